// File: doc/BRIEF.md
# Self-Timed SAR Conversion Sequencer

This block steps a 10-bit successive-approximation conversion one decision at a time. A start request ends the sampling phase. The block then enables an external comparator and waits for that comparator's ready strobe. It latches the decision, drives the switch controls of a segmented capacitor DAC and waits a programmable settling time before it asks for the next decision. No free-running bit clock paces the steps: each step begins only when the comparator reports a result. A slow or marginal decision therefore stretches only its own step.

The DAC has two segments. The upper 4 bits act on 15 equal unit groups, and each side of the differential array has its own thermometer vector. The lower 6 bits act on binary-weighted elements. The first comparison is made straight after hold, with no element switched. The four upper decisions then switch 8, 4, 2 and 1 groups on the side that the decision picks. The final decision switches nothing. The code is registered, a one-cycle done pulse is raised, and the block falls back to sampling until the next start request.

Top module: `sar_async_seq`

## Requirements
- R1: While reset is asserted and just after it is released, sample_o is 1, cmp_en_o is 0, done_o is 0, and every thermometer, binary and code output is 0.
- R2: A start_i high at a clock edge during sampling makes sample_o 0 and cmp_en_o 1 in the next cycle, with all DAC switch controls still 0.
- R3: A decision is accepted on a clock edge where cmp_en_o and cmp_rdy_i are both 1. Decisions fill the code from bit 9 down to bit 0. cmp_en_o is 0 in the cycle after each accepted decision. With an ideal comparator (decision 1 when the input is at least the trial level), the final code equals the input.
- R4: After each accepted decision except the last, cmp_en_o stays 0 for exactly SETTLE_CYC cycles and then returns to 1.
- R5: The decision on bit 9-k (k = 0..3) adds 2^(3-k) unit groups to the P side when it is 1 and to the N side when it is 0. Each side's 15-bit thermometer vector has ones exactly in bits [c-1:0], where c is that side's group count.
- R6: A decision d on bit j (j = 1..5) sets bin_p_o[j-1] = d and bin_n_o[j-1] = not d. Undecided positions are 0 on both sides.
- R7: The decision on bit 0 changes no DAC control. The next cycle has done_o = 1 for exactly one cycle, with code_o holding all ten decisions. code_o keeps that value until the next done pulse.
- R8: The cycle after done_o returns to sampling: sample_o is 1, all DAC controls are cleared, and the block waits for start_i.
- R9: cmp_rdy_i is ignored whenever cmp_en_o is 0, and start_i is ignored outside sampling. Neither changes the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to end sampling and begin a conversion |
| cmp_dec_i | input | 1 | Comparator decision, 1 when the input is at or above the trial level |
| cmp_rdy_i | input | 1 | Comparator ready strobe, valid while cmp_en_o is 1 |
| sample_o | output | 1 | Sample/hold control, 1 while tracking the input |
| cmp_en_o | output | 1 | Comparator enable for the current decision |
| therm_p_o | output | 15 | P-side thermometer group controls of the upper segment |
| therm_n_o | output | 15 | N-side thermometer group controls of the upper segment |
| bin_p_o | output | 5 | P-side controls of binary elements for bits 5..1 |
| bin_n_o | output | 5 | N-side controls of binary elements for bits 5..1 |
| code_o | output | 10 | Last completed conversion code |
| done_o | output | 1 | One-cycle pulse when a new code is ready |

## Verification
Conversions are run with an ideal comparator model that derives its trial level only from the DAC controls driven by the block. A wrong switch count, a wrong side or a wrong bit position therefore shows up as a wrong final code. The input set covers both rails, the two codes on either side of mid-scale, alternating bit patterns and one-off-the-rail values. These tell apart errors in the thermometer weighting, in the binary positions and in the handling of the final bit. The comparator latency is varied per bit, including one very long decision, to show that step timing follows the ready strobe and not a fixed count. Stray ready strobes during settling and sampling, and a stray start during conversion, show that those inputs leave the state alone.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_SAMPLE = 2'd0,
      SEQ_COMP   = 2'd1,
      SEQ_SETTLE = 2'd2,
      SEQ_DONE   = 2'd3
   } seq_state_t;
endpackage

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
   parameter int SETTLE_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expire_o
);
   localparam int TMR_W = $clog2(SETTLE_CYC + 1);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   logic [TMR_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain_q <= '0;
      else if (load_i)
         remain_q <= TMR_W'(SETTLE_CYC);
      else if (remain_q != '0)
         remain_q <= remain_q - TMR_W'(1);
   end

   assign expire_o = (remain_q == TMR_W'(1));

   // R4: once the timer is armed it must run down, never reload by itself
   p_timer_runs_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && remain_q != '0) |=> (remain_q == $past(remain_q) - TMR_W'(1)));
endmodule

// File: rtl/sar_therm_decode.sv
module sar_therm_decode #(
   parameter int MSB_BITS = 4
) (
   input  logic [MSB_BITS-1:0]          count_i,
   output logic [(1<<MSB_BITS)-2:0]     therm_o
);
   localparam int THERM_W = (1 << MSB_BITS) - 1;

   for (genvar i = 0; i < THERM_W; i++) begin : g_cell
      assign therm_o[i] = (count_i > MSB_BITS'(i));
   end
endmodule

// File: rtl/sar_async_seq.sv
module sar_async_seq
   import sar_seq_pkg::*;
#(
   parameter int MSB_BITS   = 4,
   parameter int LSB_BITS   = 6,
   parameter int SETTLE_CYC = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic                          cmp_dec_i,
   input  logic                          cmp_rdy_i,
   output logic                          sample_o,
   output logic                          cmp_en_o,
   output logic [(1<<MSB_BITS)-2:0]      therm_p_o,
   output logic [(1<<MSB_BITS)-2:0]      therm_n_o,
   output logic [LSB_BITS-2:0]           bin_p_o,
   output logic [LSB_BITS-2:0]           bin_n_o,
   output logic [MSB_BITS+LSB_BITS-1:0]  code_o,
   output logic                          done_o
);
   localparam int N_BITS  = MSB_BITS + LSB_BITS;
   localparam int THERM_W = (1 << MSB_BITS) - 1;
   localparam int BIN_W   = LSB_BITS - 1;
   localparam int IDX_W   = $clog2(N_BITS);

   if (MSB_BITS < 1 || MSB_BITS > 6) begin : g_bad_msb
      $error("MSB_BITS must lie in 1..6");
   end
   if (LSB_BITS < 2) begin : g_bad_lsb
      $error("LSB_BITS must be at least 2");
   end

   seq_state_t              state;
   logic [IDX_W-1:0]        bit_idx;
   logic [N_BITS-1:1]       work;
   logic [N_BITS-1:0]       code_q;
   logic [MSB_BITS-1:0]     cnt_p, cnt_n;
   logic [BIN_W-1:0]        bin_p_q, bin_n_q, bin_hit;
   logic [MSB_BITS-1:0]     msb_step;
   logic                    accept, last, in_msb, tmr_expire;

   assign accept = (state == SEQ_COMP) && cmp_rdy_i;
   assign last   = (bit_idx == '0);
   assign in_msb = (bit_idx >= IDX_W'(LSB_BITS));

   always_comb begin
      msb_step = '0;
      if (in_msb)
         msb_step = MSB_BITS'(1) << (bit_idx - IDX_W'(LSB_BITS));
   end

   for (genvar j = 0; j < BIN_W; j++) begin : g_bin_hit
      assign bin_hit[j] = accept && (bit_idx == IDX_W'(j + 1));
   end

   sar_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept && !last),
      .expire_o (tmr_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_SAMPLE;
         bit_idx <= '0;
         work    <= '0;
         code_q  <= '0;
         cnt_p   <= '0;
         cnt_n   <= '0;
         bin_p_q <= '0;
         bin_n_q <= '0;
      end else begin
         case (state)
            SEQ_SAMPLE: begin
               if (start_i) begin
                  state   <= SEQ_COMP;
                  bit_idx <= IDX_W'(N_BITS - 1);
                  work    <= '0;
               end
            end
            SEQ_COMP: begin
               if (cmp_rdy_i) begin
                  if (last) begin
                     code_q <= {work, cmp_dec_i};
                     state  <= SEQ_DONE;
                  end else begin
                     work[bit_idx] <= cmp_dec_i;
                     bit_idx       <= bit_idx - IDX_W'(1);
                     state         <= SEQ_SETTLE;
                  end
                  if (in_msb) begin
                     if (cmp_dec_i) cnt_p <= cnt_p + msb_step;
                     else           cnt_n <= cnt_n + msb_step;
                  end
                  bin_p_q <= (bin_p_q & ~bin_hit) | (bin_hit & {BIN_W{cmp_dec_i}});
                  bin_n_q <= (bin_n_q & ~bin_hit) | (bin_hit & {BIN_W{~cmp_dec_i}});
               end
            end
            SEQ_SETTLE: begin
               if (tmr_expire) state <= SEQ_COMP;
            end
            SEQ_DONE: begin
               state   <= SEQ_SAMPLE;
               cnt_p   <= '0;
               cnt_n   <= '0;
               bin_p_q <= '0;
               bin_n_q <= '0;
            end
            default: state <= SEQ_SAMPLE;
         endcase
      end
   end

   sar_therm_decode #(.MSB_BITS(MSB_BITS)) u_dec_p (.count_i(cnt_p), .therm_o(therm_p_o));
   sar_therm_decode #(.MSB_BITS(MSB_BITS)) u_dec_n (.count_i(cnt_n), .therm_o(therm_n_o));

   assign sample_o = (state == SEQ_SAMPLE);
   assign cmp_en_o = (state == SEQ_COMP);
   assign done_o   = (state == SEQ_DONE);
   assign bin_p_o  = bin_p_q;
   assign bin_n_o  = bin_n_q;
   assign code_o   = code_q;

   // R2: the first comparison after hold sees an unswitched DAC
   p_first_cmp_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cmp_en_o) && $past(sample_o)) |->
         (therm_p_o == '0 && therm_n_o == '0 && bin_p_o == '0 && bin_n_o == '0));

   // R3: an accepted decision always withdraws the comparator enable
   p_ack_drops_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en_o && cmp_rdy_i) |=> !cmp_en_o);

   // R5: each side's thermometer vector is a run of ones from bit 0
   p_therm_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((therm_p_o & (therm_p_o + THERM_W'(1))) == '0) &&
      ((therm_n_o & (therm_n_o + THERM_W'(1))) == '0));

   // R5: at completion the P groups equal the upper code bits, and the rest sit on N
   p_therm_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($countones(therm_p_o) == int'(code_o[N_BITS-1:LSB_BITS]) &&
                  $countones(therm_n_o) == THERM_W - int'(code_o[N_BITS-1:LSB_BITS])));

   // R7: no switching after the final decision, and done lasts one cycle
   p_lsb_no_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && last) |=> (done_o && $stable(therm_p_o) && $stable(therm_n_o) &&
                            $stable(bin_p_o) && $stable(bin_n_o)));
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && sample_o));

   // R9: during settling nothing on the DAC moves
   p_settle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_en_o && !sample_o && !done_o) |=>
         ($stable(therm_p_o) && $stable(therm_n_o) && $stable(bin_p_o) && $stable(bin_n_o)));
endmodule

// File: tb/sar_async_seq_test.sv
module sar_async_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        cmp_dec_i = 1'b0;
   logic        cmp_rdy_i = 1'b0;
   logic        sample_o, cmp_en_o, done_o;
   logic [14:0] therm_p_o, therm_n_o;
   logic [4:0]  bin_p_o, bin_n_o;
   logic [9:0]  code_o;

   sar_async_seq #(.MSB_BITS(4), .LSB_BITS(6), .SETTLE_CYC(SETTLE)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_dec_i(cmp_dec_i),
      .cmp_rdy_i(cmp_rdy_i), .sample_o(sample_o), .cmp_en_o(cmp_en_o),
      .therm_p_o(therm_p_o), .therm_n_o(therm_n_o), .bin_p_o(bin_p_o),
      .bin_n_o(bin_n_o), .code_o(code_o), .done_o(done_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;
   int cyc = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference: phase 0 sample, 1 compare, 2 settle, 3 done
   int m_phase, m_bit, m_wait, m_cp, m_cn, m_bp, m_bn, m_work, m_code;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_bit = 0; m_wait = 0; m_cp = 0; m_cn = 0;
         m_bp = 0; m_bn = 0; m_work = 0; m_code = 0;
      end else begin
         case (m_phase)
            0: if (start_i) begin
                  m_phase = 1; m_bit = 9; m_work = 0;
               end
            1: if (cmp_rdy_i) begin
                  if (cmp_dec_i) m_work = m_work | (1 << m_bit);
                  if (m_bit >= 6) begin
                     if (cmp_dec_i) m_cp = m_cp + (1 << (m_bit - 6));
                     else           m_cn = m_cn + (1 << (m_bit - 6));
                  end else if (m_bit >= 1) begin
                     if (cmp_dec_i) m_bp = m_bp | (1 << (m_bit - 1));
                     else           m_bn = m_bn | (1 << (m_bit - 1));
                  end
                  if (m_bit == 0) begin
                     m_code = m_work; m_phase = 3;
                  end else begin
                     m_phase = 2; m_wait = SETTLE; m_bit = m_bit - 1;
                  end
               end
            2: begin
                  m_wait = m_wait - 1;
                  if (m_wait == 0) m_phase = 1;
               end
            default: begin
                  m_phase = 0; m_cp = 0; m_cn = 0; m_bp = 0; m_bn = 0;
               end
         endcase
      end
   end

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (!finished) begin
         chk(sample_o == (m_phase == 0), "R8 sample_o", int'(sample_o), int'(m_phase == 0));
         chk(cmp_en_o == (m_phase == 1), "R4 cmp_en_o", int'(cmp_en_o), int'(m_phase == 1));
         chk(done_o == (m_phase == 3), "R7 done_o", int'(done_o), int'(m_phase == 3));
         chk(therm_p_o == 15'((1 << m_cp) - 1), "R5 therm_p_o", int'(therm_p_o), (1 << m_cp) - 1);
         chk(therm_n_o == 15'((1 << m_cn) - 1), "R5 therm_n_o", int'(therm_n_o), (1 << m_cn) - 1);
         chk(bin_p_o == 5'(m_bp), "R6 bin_p_o", int'(bin_p_o), m_bp);
         chk(bin_n_o == 5'(m_bn), "R6 bin_n_o", int'(bin_n_o), m_bn);
         chk(code_o == 10'(m_code), "R7 code_o", int'(code_o), m_code);
      end
   end

   function automatic int dac_level();
      int lvl;
      lvl = 64 * $countones(therm_p_o);
      for (int j = 1; j <= 5; j++)
         if (bin_p_o[j-1]) lvl = lvl + (1 << j);
      return lvl;
   endfunction

   task automatic convert(input int vin, input int seed, input bit stray);
      int lat;
      int snap_t, snap_b;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(cmp_en_o && !sample_o && therm_p_o == '0 && therm_n_o == '0 && bin_p_o == '0,
          "R2 first compare unswitched", int'(cmp_en_o), 1);
      for (int k = 9; k >= 0; k--) begin
         while (!cmp_en_o) begin
            if (stray) begin
               snap_t = int'(therm_p_o); snap_b = int'(bin_p_o);
               cmp_rdy_i = 1'b1; cmp_dec_i = 1'b1; start_i = 1'b1;
               @(negedge clk);
               cmp_rdy_i = 1'b0; start_i = 1'b0;
               chk(int'(therm_p_o) == snap_t && int'(bin_p_o) == snap_b,
                   "R9 stray strobe in settle", int'(therm_p_o), snap_t);
            end else begin
               @(negedge clk);
            end
         end
         lat = (seed + 3 * k) % 7;
         if (seed == 5 && k == 5) lat = 25;
         for (int i = 0; i < lat; i++) @(negedge clk);
         cmp_dec_i = (vin >= dac_level() + (1 << k));
         cmp_rdy_i = 1'b1;
         @(negedge clk);
         cmp_rdy_i = 1'b0;
      end
      chk(done_o == 1'b1, "R7 done after last bit", int'(done_o), 1);
      chk(int'(code_o) == vin, "R3 final code", int'(code_o), vin);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(sample_o && !cmp_en_o && !done_o && therm_p_o == '0 && bin_n_o == '0 && code_o == '0,
          "R1 reset state", int'(sample_o), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sample_o && !cmp_en_o && code_o == '0, "R1 after release", int'(sample_o), 1);
      // ready while sampling must be ignored
      cmp_rdy_i = 1'b1; cmp_dec_i = 1'b1;
      @(negedge clk);
      cmp_rdy_i = 1'b0;
      chk(sample_o && code_o == '0 && therm_p_o == '0, "R9 strobe while sampling", int'(code_o), 0);
      convert(0, 0, 1'b0);
      convert(1023, 1, 1'b0);
      convert(512, 2, 1'b0);
      convert(511, 3, 1'b1);
      convert(341, 4, 1'b0);
      convert(682, 5, 1'b0);
      convert(1, 6, 1'b1);
      convert(1022, 0, 1'b0);
      for (int v = 37; v < 1024; v += 97) convert(v, v % 7, v[0]);
      // code holds across sampling
      repeat (4) @(negedge clk);
      chk(code_o == 10'(1007) && sample_o, "R7 code held while idle", int'(code_o), 1007);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 100000);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule